// File: doc/BRIEF.md
# Track Column NOR Operation Decoder

This block turns a program drawn as K parallel text tracks into a stream of two-operand NOR operations. The drawing arrives one column per transfer, with all K track characters of the column presented together on a valid/ready handshake. Only three characters carry meaning: a source mark, a target mark, and a connector that bridges a single intervening track. Every other byte is a comment. The marks in a column must group into complete operations. An operation is a source and a target on neighbouring tracks, or on tracks two apart with a connector between them. No mark may be left over or shared between two operations.

For each legal column the block emits one (target, source) index pair per cycle, starting with the operation whose upper track is highest on the page. Each pair means that the target track becomes the NOR of the source and the target. For an illegal column the block raises a one-cycle error flag and emits nothing. A column holding no marks passes through silently. The block neither stores the program nor executes the operations; a downstream executor consumes the pairs in arrival order.

Top module: `trk_column_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, opValid and synErr are low and colReady is high.
- R2: Track i (track 0 is the top) occupies colData bits [8*(K-1-i)+7 : 8*(K-1-i)]. Byte 0x2B ('+') is a source, 0x23 ('#') a target and 0x7C ('|') a connector. Every other byte is a comment with no effect.
- R3: A source and a target on adjacent tracks form one operation, with opTarget the index of the '#' track and opSource the index of the '+' track.
- R4: A source and a target two tracks apart, with '|' on the track between them, form one legal operation.
- R5: The operations of a legal column are emitted one per cycle, beginning the cycle after the column is accepted, in ascending order of their upper track index. opValid is high exactly in those cycles.
- R6: A column is illegal if any mark is left unpaired. This covers a lone '+' or '#', a '|' not between a pair, two marks of the same kind paired, a gap that is not '|', a gap of more than one track, and a mark claimed by two operations. An illegal column raises synErr for the one cycle after its acceptance and emits no operation.
- R7: A column with no '+', '#' or '|' is accepted without any operation and without synErr.
- R8: colReady is low while more than one operation of the current column is still pending. A column is taken only on a cycle where colValid and colReady are both high, and colData has no effect on any other cycle.
- R9: In the cycle that shows the last operation of a column, a new column can be accepted. Its first operation then appears in the very next cycle with no idle cycle between, and its error flag, if any, appears in that same next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| colValid | input | 1 | A column is presented on colData |
| colReady | output | 1 | The block can take a column this cycle |
| colData | input | 8*K | One character per track, track 0 in the top byte |
| opValid | output | 1 | opTarget/opSource hold an operation |
| opTarget | output | $clog2(K) | Track overwritten by the operation |
| opSource | output | $clog2(K) | Track read as the second NOR operand |
| synErr | output | 1 | The column accepted last cycle was illegal |

## Verification
The case of interest is a cycle where the last operation of one column pops and the next column is decoded and loaded at the same edge. The bench provokes it by holding colValid high across a multi-operation column while it changes colData before the handshake completes. It then checks that the replacement column is taken only on the last-operation cycle, and that its first operation follows with no gap and no loss or repeat. A second overlap places an illegal column right behind a single-operation column. The bench checks that the error flag lands in the cycle after the final operation and that no operation leaks out with it.

// File: rtl/trk_column_pkg.sv
package trk_column_pkg;

  localparam logic [7:0] CHAR_SRC = 8'h2B;
  localparam logic [7:0] CHAR_TGT = 8'h23;
  localparam logic [7:0] CHAR_BAR = 8'h7C;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_SRC  = 2'd1,
    CL_TGT  = 2'd2,
    CL_BAR  = 2'd3
  } chClass_e;

  typedef struct packed {
    logic load;  // take a legal column into the queue
    logic drop;  // an illegal column was taken: clear the queue
    logic pop;   // retire the head operation
  } ctlStrobe_t;

  function automatic chClass_e classify(input logic [7:0] ch);
    case (ch)
      CHAR_SRC: return CL_SRC;
      CHAR_TGT: return CL_TGT;
      CHAR_BAR: return CL_BAR;
      default:  return CL_NONE;
    endcase
  endfunction

  function automatic logic isPair(input chClass_e a, input chClass_e b);
    return ((a == CL_SRC) && (b == CL_TGT)) || ((a == CL_TGT) && (b == CL_SRC));
  endfunction

endpackage

// File: rtl/trk_col_parse.sv
module trk_col_parse
  import trk_column_pkg::*;
#(
  parameter int K = 8
) (
  input  logic [8*K-1:0] colData,
  output logic [K-1:0]   startMask,
  output logic [K-1:0]   longMask,
  output logic [K-1:0]   tgtTopMask,
  output logic           parseErr
);

  localparam int PADDED = K + 2;

  chClass_e cls [PADDED];

  always_comb begin
    for (int i = 0; i < K; i++) begin
      cls[i] = classify(colData[8*(K-1-i) +: 8]);
    end
    cls[K]   = CL_NONE;
    cls[K+1] = CL_NONE;
  end

  // The top-most unclaimed mark can only pair with the next mark below it,
  // so a single top-down greedy walk decides legality uniquely.
  always_comb begin
    int skip;
    skip       = 0;
    startMask  = '0;
    longMask   = '0;
    tgtTopMask = '0;
    parseErr   = 1'b0;
    for (int i = 0; i < K; i++) begin
      if (skip > 0) begin
        skip = skip - 1;
      end else if ((cls[i] == CL_SRC) || (cls[i] == CL_TGT)) begin
        if (isPair(cls[i], cls[i+1])) begin
          startMask[i]  = 1'b1;
          tgtTopMask[i] = (cls[i] == CL_TGT);
          skip          = 1;
        end else if ((cls[i+1] == CL_BAR) && isPair(cls[i], cls[i+2])) begin
          startMask[i]  = 1'b1;
          longMask[i]   = 1'b1;
          tgtTopMask[i] = (cls[i] == CL_TGT);
          skip          = 2;
        end else begin
          parseErr = 1'b1;
        end
      end else if (cls[i] == CL_BAR) begin
        parseErr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/trk_op_queue.sv
module trk_op_queue
  import trk_column_pkg::*;
#(
  parameter int K  = 8,
  parameter int IW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic [K-1:0]  startIn,
  input  logic [K-1:0]  longIn,
  input  logic [K-1:0]  tgtTopIn,
  output logic          opValid,
  output logic          lastOp,
  output logic [IW-1:0] opTarget,
  output logic [IW-1:0] opSource
);

  logic [K-1:0]  pending;
  logic [K-1:0]  longReg;
  logic [K-1:0]  tgtTopReg;
  logic [K-1:0]  headHot;
  logic [IW-1:0] headIdx;
  logic [IW-1:0] lowIdx;
  logic          headLong;
  logic          headTgtTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      longReg   <= '0;
      tgtTopReg <= '0;
    end else if (ctl.load) begin
      pending   <= startIn;
      longReg   <= longIn;
      tgtTopReg <= tgtTopIn;
    end else if (ctl.drop) begin
      pending   <= '0;
    end else if (ctl.pop) begin
      pending   <= pending & ~headHot;
    end
  end

  assign headHot = pending & (~pending + K'(1));

  always_comb begin
    headIdx = '0;
    for (int i = 0; i < K; i++) begin
      if (headHot[i]) headIdx = headIdx | IW'(i);
    end
  end

  assign headLong   = |(longReg & headHot);
  assign headTgtTop = |(tgtTopReg & headHot);
  assign lowIdx     = headIdx + IW'(1) + IW'(headLong);

  assign opValid  = |pending;
  assign lastOp   = opValid && ((pending & ~headHot) == '0);
  assign opTarget = headTgtTop ? headIdx : lowIdx;
  assign opSource = headTgtTop ? lowIdx : headIdx;

endmodule

// File: rtl/trk_op_ctrl.sv
module trk_op_ctrl
  import trk_column_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       colValid,
  input  logic       opValid,
  input  logic       lastOp,
  input  logic       parseErr,
  output logic       colReady,
  output ctlStrobe_t ctl,
  output logic       synErr
);

  logic accept;

  assign colReady = !opValid || lastOp;
  assign accept   = colValid && colReady;

  always_comb begin
    ctl.load = accept && !parseErr;
    ctl.drop = accept && parseErr;
    ctl.pop  = opValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) synErr <= 1'b0;
    else       synErr <= accept && parseErr;
  end

endmodule

// File: rtl/trk_column_decoder.sv
module trk_column_decoder
  import trk_column_pkg::*;
#(
  parameter int K  = 8,
  parameter int IW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          colValid,
  output logic          colReady,
  input  logic [8*K-1:0] colData,
  output logic          opValid,
  output logic [IW-1:0] opTarget,
  output logic [IW-1:0] opSource,
  output logic          synErr
);

  ctlStrobe_t   ctl;
  logic [K-1:0] startMask;
  logic [K-1:0] longMask;
  logic [K-1:0] tgtTopMask;
  logic         parseErr;
  logic         lastOp;

  trk_col_parse #(.K(K)) uParse (
    .colData    (colData),
    .startMask  (startMask),
    .longMask   (longMask),
    .tgtTopMask (tgtTopMask),
    .parseErr   (parseErr)
  );

  trk_op_queue #(.K(K), .IW(IW)) uQueue (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startIn  (startMask),
    .longIn   (longMask),
    .tgtTopIn (tgtTopMask),
    .opValid  (opValid),
    .lastOp   (lastOp),
    .opTarget (opTarget),
    .opSource (opSource)
  );

  trk_op_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .colValid (colValid),
    .opValid  (opValid),
    .lastOp   (lastOp),
    .parseErr (parseErr),
    .colReady (colReady),
    .ctl      (ctl),
    .synErr   (synErr)
  );

endmodule

// File: rtl/trk_column_decoder_chk.sv
module trk_column_decoder_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          colValid,
  input logic          colReady,
  input logic          opValid,
  input logic [IW-1:0] opTarget,
  input logic [IW-1:0] opSource,
  input logic          synErr
);

  logic [IW-1:0] hiIdx;
  logic [IW-1:0] loIdx;
  logic [IW-1:0] span;

  assign hiIdx = (opTarget > opSource) ? opTarget : opSource;
  assign loIdx = (opTarget > opSource) ? opSource : opTarget;
  assign span  = hiIdx - loIdx;

  // R3 / R4: an emitted operation spans one or two tracks
  assert_span_R4: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> ((span == IW'(1)) || (span == IW'(2))));

  // R6: an error flag follows an accepted column and carries no operation
  assert_err_after_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    synErr |-> $past(colValid && colReady));

  assert_err_no_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    synErr |-> !opValid);

  // R8: the block only stalls input while operations are pending
  assert_stall_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !colReady |-> opValid);

  // R5: within one column the upper track strictly descends the page
  assert_topdown_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && $past(opValid) && !$past(colValid && colReady)) |->
      (loIdx > $past(hiIdx)));

endmodule

bind trk_column_decoder trk_column_decoder_chk #(.IW(IW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .colValid (colValid),
  .colReady (colReady),
  .opValid  (opValid),
  .opTarget (opTarget),
  .opSource (opSource),
  .synErr   (synErr)
);

// File: tb/sim_trk_column_decoder.sv
`timescale 1ns/1ps
module sim_trk_column_decoder;

  localparam int K  = 8;
  localparam int IW = 3;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          colValid = 1'b0;
  logic          colReady;
  logic [8*K-1:0] colData = '0;
  logic          opValid;
  logic [IW-1:0] opTarget;
  logic [IW-1:0] opSource;
  logic          synErr;

  int nCmp = 0;
  int nMis = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trk_column_decoder #(.K(K)) u0 (
    .clk(clk), .rstN(rstN), .colValid(colValid), .colReady(colReady),
    .colData(colData), .opValid(opValid), .opTarget(opTarget),
    .opSource(opSource), .synErr(synErr)
  );

  // Column text (first character = track 0), expected op count, error,
  // and pairs packed as octal digit pairs {target,source}, pair 0 lowest.
  localparam logic [63:0] COLS [NV] = '{
    "--------", "+#------", "#+------", "+|#-----", "#|+-----",
    "+#+#--#+", "ab+#xy#+", "#|++|#--", "+#+#+#+#", "+#+|#---",
    "+--#----", "+||#----", "--|-----", "+|#|+---", "+#|+#---",
    "++------", "-------+", "------#|"
  };
  localparam int NOPS [NV] = '{0, 1, 1, 1, 1, 3, 2, 2, 4, 2,
                               0, 0, 0, 0, 0, 0, 0, 0};
  localparam bit ERRS [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                               1, 1, 1, 1, 1, 1, 1, 1};
  localparam logic [23:0] PAIRS [NV] = '{
    24'o0, 24'o10, 24'o01, 24'o20, 24'o02,
    24'o673210, 24'o6732, 24'o5302, 24'o76543210, 24'o4210,
    24'o0, 24'o0, 24'o0, 24'o0, 24'o0, 24'o0, 24'o0, 24'o0
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      nCmp++;
      nMis++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: state during and right after reset
    repeat (3) @(negedge clk);
    chk("R1 opValid in reset", opValid, 0);
    chk("R1 synErr in reset", synErr, 0);
    chk("R1 colReady in reset", colReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 opValid after reset", opValid, 0);
    chk("R1 colReady after reset", colReady, 1);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      while (!colReady) @(negedge clk);
      colData  = COLS[v];
      colValid = 1'b1;
      @(negedge clk);
      colValid = 1'b0;
      colData  = '0;
      if (ERRS[v]) begin
        chk($sformatf("R6 synErr col %0d", v), synErr, 1);
        chk($sformatf("R6 no op col %0d", v), opValid, 0);
        @(negedge clk);
        chk($sformatf("R6 synErr single cycle col %0d", v), synErr, 0);
        chk($sformatf("R6 still no op col %0d", v), opValid, 0);
      end else begin
        chk($sformatf("R7 no synErr col %0d", v), synErr, 0);
        for (int j = 0; j < NOPS[v]; j++) begin
          chk($sformatf("R5 opValid col %0d op %0d", v, j), opValid, 1);
          chk($sformatf("R3 R4 target col %0d op %0d", v, j), opTarget, PAIRS[v][6*j+3 +: 3]);
          chk($sformatf("R3 R4 source col %0d op %0d", v, j), opSource, PAIRS[v][6*j +: 3]);
          chk($sformatf("R8 ready col %0d op %0d", v, j), colReady, (j == NOPS[v]-1));
          @(negedge clk);
        end
        chk($sformatf("R5 R7 idle after col %0d", v), opValid, 0);
      end
    end

    // R8 R9: column held while busy, taken on the last-op cycle, then an
    // illegal column right behind a single op.
    colData  = "+#+#----";
    colValid = 1'b1;
    @(negedge clk);
    chk("R8 busy op0 valid", opValid, 1);
    chk("R8 busy op0 target", opTarget, 1);
    chk("R8 ready low with two pending", colReady, 0);
    colData = "#+------";
    @(negedge clk);
    chk("R9 op1 target", opTarget, 3);
    chk("R9 op1 source", opSource, 2);
    chk("R9 ready on last op", colReady, 1);
    @(negedge clk);
    chk("R9 next col op valid no gap", opValid, 1);
    chk("R9 next col target", opTarget, 0);
    chk("R9 next col source", opSource, 1);
    chk("R9 next col synErr", synErr, 0);
    colData = "--|-----";
    @(negedge clk);
    colValid = 1'b0;
    colData  = "+#------";
    chk("R9 err right after op", synErr, 1);
    chk("R9 err col emits nothing", opValid, 0);
    @(negedge clk);
    chk("R8 data without valid ignored", opValid, 0);
    chk("R8 data without valid no err", synErr, 0);

    // R1: asynchronous reset in the middle of a column
    colData  = "+#+#+#+#";
    colValid = 1'b1;
    @(negedge clk);
    colValid = 1'b0;
    chk("R1 pre-reset op valid", opValid, 1);
    rstN = 1'b0;
    #1;
    chk("R1 reset clears ops", opValid, 0);
    chk("R1 reset ready", colReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 no op after reset", opValid, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule